// File: doc/BRIEF.md
# Bus Wait-State Acknowledge Generator

This block sits beside a bus controller that runs from a fast input clock. It divides that clock by two to make the system clock. It also returns an active-low transfer acknowledge that lags the controller's active-low chip select by exactly one system-clock cycle, which gives every access one wait state.

Chip select is never passed straight through to the acknowledge. It is sampled on each falling edge of the divided clock and moves through a two-stage shift register. The acknowledge asserts only when both stages hold a low sample. It deasserts at the first falling edge that samples chip select high.

While the controller drives its active-low DMA acknowledge, the transfer acknowledge is held high. The sampled chip-select history is left untouched, so the acknowledge comes back once DMA acknowledge is released.

All registers run on the fast clock. A falling edge of the divided clock is the fast-clock edge at which the divider goes from high to low. Reset is synchronous and active low.

Top module: `waitack_gen`

## Requirements
- R1: While reset is released, `sys_clk` inverts on every rising edge of `clk_fast`, so its period is two fast-clock cycles.
- R2: At any `clk_fast` edge with `rst_n` low, `sys_clk` goes to 0 and `xfer_ack_n` goes to 1. Both keep these values until reset is released.
- R3: `cs_n` is sampled only at a falling edge of `sys_clk`, meaning the fast edge at which `sys_clk` goes from 1 to 0. A change of `cs_n` that is undone before the next such edge has no effect on `xfer_ack_n`.
- R4: At the first falling edge that samples `cs_n` low after a high sample, `xfer_ack_n` stays 1. This is the wait state.
- R5: At the second consecutive falling edge that samples `cs_n` low, `xfer_ack_n` goes to 0, provided `dma_ack_n` is 1.
- R6: `xfer_ack_n` stays 0 for as long as every following sample of `cs_n` is low and `dma_ack_n` is 1.
- R7: At the first falling edge that samples `cs_n` high, `xfer_ack_n` returns to 1 at that same edge.
- R8: While `dma_ack_n` is 0, `xfer_ack_n` is 1 in the same cycle, with no clock edge needed. Releasing `dma_ack_n` restores the acknowledge that the sampled chip-select history calls for.
- R9: Chip-select cycles separated by one or more high samples each get exactly one wait state.
- R10: With `dma_ack_n` steady at 1, `xfer_ack_n` changes only at falling edges of `sys_clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast input clock; all registers use its rising edge |
| rst_n | input | 1 | Synchronous active-low master reset |
| cs_n | input | 1 | Active-low chip select from the bus controller |
| dma_ack_n | input | 1 | Active-low DMA acknowledge from the bus controller |
| sys_clk | output | 1 | Fast clock divided by two |
| xfer_ack_n | output | 1 | Active-low transfer acknowledge with one wait state |

## Verification
The assertions assume two things. First, `cs_n` and `dma_ack_n` change only between fast-clock edges. Second, a level present at a falling edge of `sys_clk` is the one the controller means to signal. The bench therefore changes every input one time unit after a rising edge of `clk_fast`, so no input moves at a sampling edge. Every chip-select change is placed against a known falling edge of `sys_clk`, including a pulse that is deliberately withdrawn before any sampling edge. DMA acknowledge is toggled in the middle of a cycle so that its same-cycle effect can be seen apart from the sampling edges.

// File: rtl/wag_pkg.sv
// Shared definitions for the wait-state acknowledge generator.
// Assumes nothing beyond a single fast clock domain.
package wag_pkg;
    // Default depth of the chip-select delay line (one wait state).
    parameter int WAG_DEFAULT_STAGES = 2;

    // Phase of the divide-by-two register.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } div_phase_e;
endpackage

// File: rtl/wag_clkdiv.sv
// Divide-by-two of the fast clock. It also flags the fast edge at which the
// divided clock will fall, so downstream logic can stay in the fast domain.
// Assumes a synchronous active-low reset that parks the divided clock low.
module wag_clkdiv
    import wag_pkg::*;
(
    input  logic clk_fast,
    input  logic rst_n,
    output logic sys_clk,
    output logic fall_en
);
    div_phase_e phase_q;

    // Toggle the phase on every fast edge; reset parks it low.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) phase_q <= PH_LOW;
        else        phase_q <= (phase_q == PH_HIGH) ? PH_LOW : PH_HIGH;
    end

    assign sys_clk = (phase_q == PH_HIGH);
    // The next fast edge takes the divided clock from high to low.
    assign fall_en = (phase_q == PH_HIGH);

    // R1
    sysclk_toggle_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        rst_n |=> (sys_clk != $past(sys_clk)));

    // R2
    reset_low_chk: assert property (@(posedge clk_fast)
        !rst_n |=> !sys_clk);
endmodule

// File: rtl/wag_cs_shift.sv
// Shift register that samples chip select at each divided-clock falling
// edge. Stage 0 holds the newest sample. All stages reset to the idle level.
// Assumes fall_en is high for exactly one fast cycle per divided period.
module wag_cs_shift #(
    parameter int STAGES = 2
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic              fall_en,
    input  logic              cs_n,
    output logic [STAGES-1:0] stages_q
);
    // First stage: capture chip select at the sampling edge.
    always_ff @(posedge clk_fast) begin
        if (!rst_n)       stages_q[0] <= 1'b1;
        else if (fall_en) stages_q[0] <= cs_n;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // Later stage: take the older sample from the stage before it.
        always_ff @(posedge clk_fast) begin
            if (!rst_n)       stages_q[i] <= 1'b1;
            else if (fall_en) stages_q[i] <= stages_q[i-1];
        end
    end

    // R3
    hold_between_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (rst_n && !fall_en) |=> $stable(stages_q));
endmodule

// File: rtl/wag_ack_gate.sv
// Forms the active-low acknowledge. It asserts only when every delay stage
// holds a low sample, and it is blocked while DMA acknowledge is active.
// Assumes dma_ack_n is driven by the same controller in the fast domain.
module wag_ack_gate #(
    parameter int STAGES = 2
) (
    input  logic [STAGES-1:0] stages_q,
    input  logic              dma_ack_n,
    output logic              xfer_ack_n
);
    // Combine the delay-line history with the DMA block.
    always_comb begin
        xfer_ack_n = (|stages_q) | ~dma_ack_n;
    end
endmodule

// File: rtl/waitack_gen.sv
// Top level: divided system clock plus a transfer acknowledge that lags chip
// select by STAGES-1 system-clock cycles (one wait state by default).
// Assumes the inputs change away from rising edges of clk_fast.
module waitack_gen
    import wag_pkg::*;
#(
    parameter int STAGES = WAG_DEFAULT_STAGES
) (
    input  logic clk_fast,
    input  logic rst_n,
    input  logic cs_n,
    input  logic dma_ack_n,
    output logic sys_clk,
    output logic xfer_ack_n
);
    logic              fall_en;
    logic [STAGES-1:0] stages_q;

    wag_clkdiv u_div (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .sys_clk  (sys_clk),
        .fall_en  (fall_en)
    );

    wag_cs_shift #(.STAGES(STAGES)) u_shift (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .fall_en  (fall_en),
        .cs_n     (cs_n),
        .stages_q (stages_q)
    );

    wag_ack_gate #(.STAGES(STAGES)) u_gate (
        .stages_q   (stages_q),
        .dma_ack_n  (dma_ack_n),
        .xfer_ack_n (xfer_ack_n)
    );

    // Checker-side record of the previous chip-select sample.
    logic prev_sample_q;
    // Track the last sampled chip-select level for the assertions.
    always_ff @(posedge clk_fast) begin
        if (!rst_n)       prev_sample_q <= 1'b1;
        else if (fall_en) prev_sample_q <= cs_n;
    end

    // R4
    first_low_wait_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (fall_en && !cs_n && prev_sample_q) |=> xfer_ack_n);

    // R5
    second_low_ack_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (STAGES == 2 && fall_en && !cs_n && !prev_sample_q) |=> (!xfer_ack_n || !dma_ack_n));

    // R7
    high_sample_release_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (fall_en && cs_n) |=> xfer_ack_n);

    // R8
    dma_block_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !dma_ack_n |-> xfer_ack_n);

    // R10
    edge_only_change_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (rst_n && !fall_en && dma_ack_n) |=> (!dma_ack_n || $stable(xfer_ack_n)));

    // R2
    reset_ack_idle_chk: assert property (@(posedge clk_fast)
        !rst_n |=> xfer_ack_n);
endmodule

// File: tb/waitack_gen_tb.sv
module waitack_gen_tb_top;
    logic clk_fast = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic dma_ack_n = 1'b1;
    logic sys_clk;
    logic xfer_ack_n;

    int total = 0;
    int bad = 0;

    waitack_gen dut_i (
        .clk_fast   (clk_fast),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .dma_ack_n  (dma_ack_n),
        .sys_clk    (sys_clk),
        .xfer_ack_n (xfer_ack_n)
    );

    always #5 clk_fast = ~clk_fast;

    task automatic check(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk_fast);
        #1;
    endtask

    // Advance to just after the next falling edge of sys_clk.
    task automatic wait_fall();
        while (sys_clk !== 1'b1) step();
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) step();
        check(sys_clk, 1'b0, "R2 sys_clk in reset");
        check(xfer_ack_n, 1'b1, "R2 ack in reset");
        rst_n = 1'b1;
    endtask

    task automatic t_divider();
        logic prev;
        step();
        prev = sys_clk;
        for (int i = 0; i < 8; i++) begin
            step();
            check(sys_clk, ~prev, "R1 toggle");
            prev = sys_clk;
        end
    endtask

    task automatic t_single();
        wait_fall();
        cs_n = 1'b0;
        wait_fall();
        check(xfer_ack_n, 1'b1, "R4 first low sample");
        step();
        check(xfer_ack_n, 1'b1, "R10 no change mid cycle");
        wait_fall();
        check(xfer_ack_n, 1'b0, "R5 second low sample");
        step();
        check(xfer_ack_n, 1'b0, "R10 held mid cycle");
        cs_n = 1'b1;
        wait_fall();
        check(xfer_ack_n, 1'b1, "R7 high sample releases");
    endtask

    task automatic t_glitch();
        wait_fall();
        cs_n = 1'b0;
        step();
        cs_n = 1'b1;
        wait_fall();
        check(xfer_ack_n, 1'b1, "R3 unsampled pulse 1");
        wait_fall();
        check(xfer_ack_n, 1'b1, "R3 unsampled pulse 2");
    endtask

    task automatic t_hold();
        wait_fall();
        cs_n = 1'b0;
        wait_fall();
        wait_fall();
        for (int i = 0; i < 4; i++) begin
            check(xfer_ack_n, 1'b0, "R6 held low");
            wait_fall();
        end
        cs_n = 1'b1;
        wait_fall();
        check(xfer_ack_n, 1'b1, "R7 release after hold");
    endtask

    task automatic t_back_to_back();
        wait_fall();
        cs_n = 1'b0;
        wait_fall();
        wait_fall();
        check(xfer_ack_n, 1'b0, "R9 first cycle ack");
        cs_n = 1'b1;
        wait_fall();
        check(xfer_ack_n, 1'b1, "R9 gap");
        cs_n = 1'b0;
        wait_fall();
        check(xfer_ack_n, 1'b1, "R9 second cycle wait state");
        wait_fall();
        check(xfer_ack_n, 1'b0, "R9 second cycle ack");
        cs_n = 1'b1;
        wait_fall();
    endtask

    task automatic t_dma();
        wait_fall();
        cs_n = 1'b0;
        wait_fall();
        wait_fall();
        check(xfer_ack_n, 1'b0, "R8 ack before dma");
        dma_ack_n = 1'b0;
        #1;
        check(xfer_ack_n, 1'b1, "R8 dma blocks immediately");
        wait_fall();
        check(xfer_ack_n, 1'b1, "R8 dma blocks across edge");
        dma_ack_n = 1'b1;
        #1;
        check(xfer_ack_n, 1'b0, "R8 ack restored");
        cs_n = 1'b1;
        wait_fall();
    endtask

    task automatic t_mid_reset();
        wait_fall();
        cs_n = 1'b0;
        wait_fall();
        wait_fall();
        rst_n = 1'b0;
        step();
        check(xfer_ack_n, 1'b1, "R2 ack cleared by reset");
        check(sys_clk, 1'b0, "R2 sys_clk cleared by reset");
        cs_n = 1'b1;
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step();
        t_reset();
        t_divider();
        t_single();
        t_glitch();
        t_hold();
        t_back_to_back();
        t_dma();
        t_mid_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule